// File: doc/BRIEF.md
# Hysteresis Threshold Register Encoder

This block holds a low (falling) and a high (rising) switching threshold for each of several sensing modes, and turns requests to change one of them into the 16-bit word that a downstream threshold register expects. That word does not hold the thresholds themselves. Its upper byte is the hysteresis (high minus low) and its lower byte is the sum (high plus low). The receiving register misbehaves on an odd hysteresis. Because of that, the encoder quietly moves the opposite threshold by one step whenever a request would leave the gap odd.

Each request names a mode, a direction and a value. The block checks the value against the legal range and the minimum gap, and answers with a one-cycle accept or reject pulse. When an accepted request changes a stored value, the block issues the new word on a valid/ready write port. It takes no further request until that write has been taken. After reset it first writes the default word to every mode's register, in ascending mode order. A side port reads back the stored pair of any mode. A separate combinational port decodes any register word back into its low and high thresholds.

Top module: `thr_hyst_encoder`

## Requirements
- R1: A register word carries high minus low in bits 15:8 and high plus low (modulo 256) in bits 7:0.
- R2: A falling request (req_rising = 0) is accepted only if its value lies in 2..21 and value + 2 is at most the stored high threshold of that mode; otherwise it is rejected.
- R3: A rising request (req_rising = 1) is accepted only if its value lies in 3..22 and it is at least the stored low threshold + 2; otherwise it is rejected.
- R4: An accepted falling request stores the value as the new low threshold and, when high minus the new low is odd, lowers the high threshold by 1.
- R5: An accepted rising request stores the value as the new high threshold and, when the new high minus low is odd, raises the low threshold by 1; every stored pair keeps an even gap of at least 2.
- R6: An accepted request whose value equals the stored threshold of that direction is answered with rsp_ok and produces no register write.
- R7: After reset every mode holds low = 2 and high = 4. The block writes word 0x0206 to mode 0, then to mode 1, and keeps req_ready low until both writes are taken.
- R8: The decode port returns low = (bits 7:0 − bits 15:8)/2 and high = (bits 7:0 + bits 15:8)/2 for any word.
- R9: The answer appears in the cycle after the request is taken, as a one-cycle rsp_ok or rsp_err, never both. A rejected request changes no stored threshold and writes nothing.
- R10: While a write is pending, req_ready is low, and wr_valid, wr_mode and wr_data hold steady until wr_ready is seen.
- R11: A request touches only its own mode's thresholds, and its write carries that mode on wr_mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_mode | input | 1 | Sensing mode the request targets |
| req_rising | input | 1 | 1: set high (rising) threshold, 0: set low (falling) threshold |
| req_value | input | 8 | Requested threshold value |
| rsp_ok | output | 1 | One-cycle pulse: request accepted |
| rsp_err | output | 1 | One-cycle pulse: request rejected |
| wr_valid | output | 1 | Register write pending |
| wr_ready | input | 1 | Register write taken |
| wr_mode | output | 1 | Mode whose register is written |
| wr_data | output | 16 | Register word {hysteresis, sum} |
| rd_mode | input | 1 | Mode selected for read-back |
| rd_low | output | 8 | Stored low threshold of rd_mode |
| rd_high | output | 8 | Stored high threshold of rd_mode |
| dec_word | input | 16 | Register word to decode |
| dec_low | output | 8 | Decoded low threshold |
| dec_high | output | 8 | Decoded high threshold |

## Verification
The bench aims at the edges of the acceptance rules: the lowest and highest legal values, a gap of exactly 2, and values one step outside each limit. A comparison off by one there would accept a request that should fail or refuse a legal one. It forces both odd-gap corrections, which a design that skips them would reveal through an odd hysteresis byte or a wrong read-back pair. It repeats stored values to catch a spurious write, and it holds wr_ready low to catch a write that drops or changes before it is taken. Reset defaults, the order of the boot writes, and mode isolation are checked by reading back both modes after every step.

// File: rtl/thr_pkg.sv
// Shared types for the hysteresis threshold encoder.
// Assumes: the controller uses these state codes only internally.
package thr_pkg;

    // Controller states: boot, default-word writes, idle, pending update write
    typedef enum logic [1:0] {
        ST_BOOT  = 2'd0,
        ST_INIT  = 2'd1,
        ST_IDLE  = 2'd2,
        ST_WRITE = 2'd3
    } thr_state_e;

    // Request direction encoding on req_rising
    localparam logic DIR_FALL = 1'b0;
    localparam logic DIR_RISE = 1'b1;

endpackage

// File: rtl/thr_req_check.sv
// Validates one threshold request against the stored pair of its mode,
// applies the even-gap correction and forms the register word.
// Assumes: cur_lo/cur_hi already obey the even gap of at least MIN_HYST.
module thr_req_check #(
    parameter int VAL_W    = 8,
    parameter int MIN_LO   = 2,
    parameter int MAX_LO   = 21,
    parameter int MIN_HI   = 3,
    parameter int MAX_HI   = 22,
    parameter int MIN_HYST = 2
) (
    input  logic               rising,
    input  logic [VAL_W-1:0]   value,
    input  logic [VAL_W-1:0]   cur_lo,
    input  logic [VAL_W-1:0]   cur_hi,
    output logic               accept,
    output logic               changed,
    output logic [VAL_W-1:0]   new_lo,
    output logic [VAL_W-1:0]   new_hi,
    output logic [2*VAL_W-1:0] word
);
    import thr_pkg::*;

    localparam logic [VAL_W:0] MIN_LO_V = (VAL_W+1)'(MIN_LO);
    localparam logic [VAL_W:0] MAX_LO_V = (VAL_W+1)'(MAX_LO);
    localparam logic [VAL_W:0] MIN_HI_V = (VAL_W+1)'(MIN_HI);
    localparam logic [VAL_W:0] MAX_HI_V = (VAL_W+1)'(MAX_HI);
    localparam logic [VAL_W:0] HYST_V   = (VAL_W+1)'(MIN_HYST);

    logic [VAL_W:0] val_x, lo_x, hi_x;
    logic           fall_ok, rise_ok;
    logic [VAL_W:0] sum_x;

    // Widen operands so the gap comparisons cannot wrap
    always_comb begin
        val_x = {1'b0, value};
        lo_x  = {1'b0, cur_lo};
        hi_x  = {1'b0, cur_hi};
    end

    // Acceptance rules per direction
    always_comb begin
        fall_ok = (val_x >= MIN_LO_V) && (val_x <= MAX_LO_V) && ((val_x + HYST_V) <= hi_x);
        rise_ok = (val_x >= MIN_HI_V) && (val_x <= MAX_HI_V) && (val_x >= (lo_x + HYST_V));
        accept  = (rising == DIR_RISE) ? rise_ok : fall_ok;
    end

    // New pair with the odd-gap correction on the opposite threshold
    always_comb begin
        if (rising == DIR_RISE) begin
            changed = (value != cur_hi);
            new_hi  = value;
            new_lo  = (value[0] ^ cur_lo[0]) ? cur_lo + VAL_W'(1) : cur_lo;
        end else begin
            changed = (value != cur_lo);
            new_lo  = value;
            new_hi  = (value[0] ^ cur_hi[0]) ? cur_hi - VAL_W'(1) : cur_hi;
        end
    end

    // Register word: gap in the upper half, sum in the lower half
    always_comb begin
        sum_x = {1'b0, new_hi} + {1'b0, new_lo};
        word  = {new_hi - new_lo, sum_x[VAL_W-1:0]};
    end

endmodule

// File: rtl/thr_mode_store.sv
// Holds the low/high threshold pair of every sensing mode.
// Assumes: at most one mode is written per cycle; reset loads the defaults.
module thr_mode_store #(
    parameter int NUM_MODES = 2,
    parameter int MODE_W    = 1,
    parameter int VAL_W     = 8,
    parameter int RST_LO    = 2,
    parameter int RST_HI    = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [MODE_W-1:0]          wmode,
    input  logic [VAL_W-1:0]           wlo,
    input  logic [VAL_W-1:0]           whi,
    output logic [NUM_MODES*VAL_W-1:0] lo_flat,
    output logic [NUM_MODES*VAL_W-1:0] hi_flat
);
    localparam logic [VAL_W-1:0] RST_LO_V = VAL_W'(RST_LO);
    localparam logic [VAL_W-1:0] RST_HI_V = VAL_W'(RST_HI);

    for (genvar g = 0; g < NUM_MODES; g++) begin : g_mode
        logic [VAL_W-1:0] lo_q, hi_q;

        // Per-mode pair register, written when its mode is selected
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lo_q <= RST_LO_V;
                hi_q <= RST_HI_V;
            end else if (we && (int'(wmode) == g)) begin
                lo_q <= wlo;
                hi_q <= whi;
            end
        end

        assign lo_flat[g*VAL_W +: VAL_W] = lo_q;
        assign hi_flat[g*VAL_W +: VAL_W] = hi_q;
    end

endmodule

// File: rtl/thr_word_decode.sv
// Turns a {gap, sum} register word back into its low and high thresholds.
// Assumes: the word was formed with an even gap; pure combinational.
module thr_word_decode #(
    parameter int VAL_W = 8
) (
    input  logic [2*VAL_W-1:0] word,
    output logic [VAL_W-1:0]   low,
    output logic [VAL_W-1:0]   high
);
    logic [VAL_W-1:0] gap, sum, diff;
    logic [VAL_W:0]   tot;

    // Split the word and halve difference and total
    always_comb begin
        gap  = word[2*VAL_W-1:VAL_W];
        sum  = word[VAL_W-1:0];
        diff = sum - gap;
        tot  = {1'b0, sum} + {1'b0, gap};
        low  = {1'b0, diff[VAL_W-1:1]};
        high = tot[VAL_W:1];
    end

endmodule

// File: rtl/thr_hyst_encoder.sv
// Top of the hysteresis threshold encoder: takes one request at a time,
// answers accept/reject, and emits the register word over valid/ready.
// Assumes: the register sink raises wr_ready eventually; reset is synchronous.
module thr_hyst_encoder #(
    parameter int NUM_MODES = 2,
    parameter int VAL_W     = 8,
    parameter int MIN_LO    = 2,
    parameter int MAX_LO    = 21,
    parameter int MIN_HI    = 3,
    parameter int MAX_HI    = 22,
    parameter int MIN_HYST  = 2,
    parameter int RST_LO    = 2,
    parameter int RST_HI    = 4,
    localparam int MODE_W   = (NUM_MODES > 1) ? $clog2(NUM_MODES) : 1,
    localparam int WORD_W   = 2 * VAL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [MODE_W-1:0] req_mode,
    input  logic              req_rising,
    input  logic [VAL_W-1:0]  req_value,
    output logic              rsp_ok,
    output logic              rsp_err,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [MODE_W-1:0] wr_mode,
    output logic [WORD_W-1:0] wr_data,
    input  logic [MODE_W-1:0] rd_mode,
    output logic [VAL_W-1:0]  rd_low,
    output logic [VAL_W-1:0]  rd_high,
    input  logic [WORD_W-1:0] dec_word,
    output logic [VAL_W-1:0]  dec_low,
    output logic [VAL_W-1:0]  dec_high
);
    import thr_pkg::*;

    localparam logic [MODE_W-1:0] LAST_MODE = MODE_W'(NUM_MODES - 1);
    localparam logic [VAL_W-1:0]  RST_GAP   = VAL_W'(RST_HI - RST_LO);
    localparam logic [VAL_W-1:0]  RST_SUM   = VAL_W'(RST_HI + RST_LO);
    localparam logic [WORD_W-1:0] RST_WORD  = {RST_GAP, RST_SUM};

    thr_state_e              state;
    logic [MODE_W-1:0]       wr_mode_q;
    logic [WORD_W-1:0]       wr_data_q;
    logic                    rsp_ok_q, rsp_err_q;
    logic [NUM_MODES*VAL_W-1:0] lo_flat, hi_flat;
    logic [VAL_W-1:0]        cur_lo, cur_hi, new_lo, new_hi;
    logic                    rule_ok, changed, mode_ok, accept, fire, upd;
    logic [WORD_W-1:0]       new_word;

    // Guard against mode codes beyond NUM_MODES when it is not a power of two
    if (NUM_MODES == (1 << MODE_W)) begin : g_full_modes
        assign mode_ok = 1'b1;
    end else begin : g_part_modes
        assign mode_ok = (int'(req_mode) < NUM_MODES);
    end

    // Pick the stored pair of the requested mode and of the read-back mode
    always_comb begin
        cur_lo  = lo_flat[req_mode*VAL_W +: VAL_W];
        cur_hi  = hi_flat[req_mode*VAL_W +: VAL_W];
        rd_low  = lo_flat[rd_mode*VAL_W +: VAL_W];
        rd_high = hi_flat[rd_mode*VAL_W +: VAL_W];
    end

    thr_req_check #(
        .VAL_W(VAL_W), .MIN_LO(MIN_LO), .MAX_LO(MAX_LO),
        .MIN_HI(MIN_HI), .MAX_HI(MAX_HI), .MIN_HYST(MIN_HYST)
    ) u_check (
        .rising (req_rising),
        .value  (req_value),
        .cur_lo (cur_lo),
        .cur_hi (cur_hi),
        .accept (rule_ok),
        .changed(changed),
        .new_lo (new_lo),
        .new_hi (new_hi),
        .word   (new_word)
    );

    // Handshake and update qualifiers
    always_comb begin
        req_ready = (state == ST_IDLE);
        fire      = req_valid && req_ready;
        accept    = rule_ok && mode_ok;
        upd       = fire && accept && changed;
    end

    thr_mode_store #(
        .NUM_MODES(NUM_MODES), .MODE_W(MODE_W), .VAL_W(VAL_W),
        .RST_LO(RST_LO), .RST_HI(RST_HI)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (upd),
        .wmode  (req_mode),
        .wlo    (new_lo),
        .whi    (new_hi),
        .lo_flat(lo_flat),
        .hi_flat(hi_flat)
    );

    thr_word_decode #(.VAL_W(VAL_W)) u_decode (
        .word(dec_word),
        .low (dec_low),
        .high(dec_high)
    );

    // Controller: boot writes, request intake and pending write tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_BOOT;
            wr_mode_q <= '0;
            wr_data_q <= RST_WORD;
            rsp_ok_q  <= 1'b0;
            rsp_err_q <= 1'b0;
        end else begin
            rsp_ok_q  <= fire && accept;
            rsp_err_q <= fire && !accept;
            case (state)
                ST_BOOT: begin
                    state     <= ST_INIT;
                    wr_mode_q <= '0;
                    wr_data_q <= RST_WORD;
                end
                ST_INIT: begin
                    if (wr_ready) begin
                        if (wr_mode_q == LAST_MODE) state <= ST_IDLE;
                        else                        wr_mode_q <= wr_mode_q + MODE_W'(1);
                    end
                end
                ST_IDLE: begin
                    if (upd) begin
                        state     <= ST_WRITE;
                        wr_mode_q <= req_mode;
                        wr_data_q <= new_word;
                    end
                end
                ST_WRITE: begin
                    if (wr_ready) state <= ST_IDLE;
                end
                default: state <= ST_BOOT;
            endcase
        end
    end

    // Output drive from the controller registers
    always_comb begin
        wr_valid = (state == ST_INIT) || (state == ST_WRITE);
        wr_mode  = wr_mode_q;
        wr_data  = wr_data_q;
        rsp_ok   = rsp_ok_q;
        rsp_err  = rsp_err_q;
    end

endmodule

// File: rtl/thr_hyst_encoder_chk.sv
// Property checker for thr_hyst_encoder, attached by bind below.
// Assumes: it observes the top's ports and its flattened threshold store.
module thr_hyst_encoder_chk #(
    parameter int NUM_MODES = 2,
    parameter int VAL_W     = 8,
    parameter int MODE_W    = 1,
    parameter int MIN_HYST  = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       req_valid,
    input logic                       req_ready,
    input logic                       rsp_ok,
    input logic                       rsp_err,
    input logic                       wr_valid,
    input logic                       wr_ready,
    input logic [MODE_W-1:0]          wr_mode,
    input logic [2*VAL_W-1:0]         wr_data,
    input logic [NUM_MODES*VAL_W-1:0] lo_flat,
    input logic [NUM_MODES*VAL_W-1:0] hi_flat
);
    localparam logic [VAL_W-1:0] HYST_V = VAL_W'(MIN_HYST);

    // Every emitted word carries an even gap of at least the minimum
    assert_even_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_data[VAL_W] == 1'b0) && (wr_data[2*VAL_W-1:VAL_W] >= HYST_V));

    // A write not yet taken stays up and unchanged
    assert_wr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> wr_valid && $stable(wr_data) && $stable(wr_mode));

    // No request intake while a write is pending
    assert_no_intake_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !req_ready);

    // Accept and reject never coincide
    assert_resp_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_ok && rsp_err));

    // A response always follows a request taken one cycle earlier
    assert_resp_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_ok || rsp_err) |-> $past(req_valid && req_ready));

    // A rejected request left every stored threshold as it was
    assert_reject_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> ($stable(lo_flat) && $stable(hi_flat)));

    for (genvar g = 0; g < NUM_MODES; g++) begin : g_pair
        // Stored pair of each mode keeps an even gap of at least the minimum
        assert_pair_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (((hi_flat[g*VAL_W +: VAL_W] - lo_flat[g*VAL_W +: VAL_W]) & VAL_W'(1)) == '0) &&
            (hi_flat[g*VAL_W +: VAL_W] >= lo_flat[g*VAL_W +: VAL_W] + HYST_V));
    end

endmodule

bind thr_hyst_encoder thr_hyst_encoder_chk #(
    .NUM_MODES(NUM_MODES), .VAL_W(VAL_W), .MODE_W(MODE_W), .MIN_HYST(MIN_HYST)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .rsp_ok   (rsp_ok),
    .rsp_err  (rsp_err),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_mode  (wr_mode),
    .wr_data  (wr_data),
    .lo_flat  (lo_flat),
    .hi_flat  (hi_flat)
);

// File: tb/tb_thr_hyst_encoder.sv
module tb_thr_hyst_encoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [0:0]  req_mode = '0;
    logic        req_rising = 1'b0;
    logic [7:0]  req_value = '0;
    logic        rsp_ok, rsp_err;
    logic        wr_valid;
    logic        wr_ready = 1'b0;
    logic [0:0]  wr_mode;
    logic [15:0] wr_data;
    logic [0:0]  rd_mode = '0;
    logic [7:0]  rd_low, rd_high;
    logic [15:0] dec_word = '0;
    logic [7:0]  dec_low, dec_high;

    int total = 0;
    int bad   = 0;
    int mlo [2];
    int mhi [2];

    always #10 clk = ~clk;

    thr_hyst_encoder dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_mode(req_mode),
        .req_rising(req_rising), .req_value(req_value),
        .rsp_ok(rsp_ok), .rsp_err(rsp_err),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_mode(wr_mode), .wr_data(wr_data),
        .rd_mode(rd_mode), .rd_low(rd_low), .rd_high(rd_high),
        .dec_word(dec_word), .dec_low(dec_low), .dec_high(dec_high)
    );

    typedef struct packed {
        logic       mode;
        logic       rise;
        logic [7:0] val;
        logic       ok;
        logic       wr;
        logic [7:0] lo;
        logic [7:0] hi;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b1, 8'd10, 1'b1, 1'b1, 8'd2,  8'd10},  // R3 rise, even gap
        '{1'b0, 1'b0, 8'd5,  1'b1, 1'b1, 8'd5,  8'd9 },  // R4 odd gap, high drops
        '{1'b0, 1'b1, 8'd8,  1'b1, 1'b1, 8'd6,  8'd8 },  // R5 odd gap, low rises
        '{1'b0, 1'b0, 8'd7,  1'b0, 1'b0, 8'd6,  8'd8 },  // R2 gap too small
        '{1'b0, 1'b1, 8'd7,  1'b0, 1'b0, 8'd6,  8'd8 },  // R3 gap too small
        '{1'b0, 1'b1, 8'd8,  1'b1, 1'b0, 8'd6,  8'd8 },  // R6 same high
        '{1'b0, 1'b0, 8'd1,  1'b0, 1'b0, 8'd6,  8'd8 },  // R2 below range
        '{1'b1, 1'b1, 8'd23, 1'b0, 1'b0, 8'd2,  8'd4 },  // R3 above range
        '{1'b1, 1'b1, 8'd22, 1'b1, 1'b1, 8'd2,  8'd22},  // R3 top of range, R11
        '{1'b1, 1'b0, 8'd21, 1'b0, 1'b0, 8'd2,  8'd22},  // R2 top of range, gap short
        '{1'b1, 1'b0, 8'd20, 1'b1, 1'b1, 8'd20, 8'd22},  // R2 gap exactly 2
        '{1'b1, 1'b0, 8'd2,  1'b1, 1'b1, 8'd2,  8'd22},  // R2 bottom of range
        '{1'b1, 1'b0, 8'd3,  1'b1, 1'b1, 8'd3,  8'd21},  // R4 odd gap, high drops
        '{1'b0, 1'b0, 8'd6,  1'b1, 1'b0, 8'd6,  8'd8 },  // R6 same low
        '{1'b1, 1'b1, 8'd3,  1'b0, 1'b0, 8'd3,  8'd21},  // R3 gap short
        '{1'b0, 1'b0, 8'd2,  1'b1, 1'b1, 8'd2,  8'd8 },  // R2 bottom, even gap
        '{1'b0, 1'b1, 8'd4,  1'b1, 1'b1, 8'd2,  8'd4 }   // R3 gap exactly 2
    };

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic int word_of(input int lo, input int hi);
        return ((hi - lo) << 8) | ((hi + lo) & 8'hFF);
    endfunction

    // Read back both modes and compare with the bench model (R11)
    task automatic check_pairs(input string req);
        for (int m = 0; m < 2; m++) begin
            rd_mode = 1'(m);
            #1;
            chk({req, " low"},  int'(rd_low),  mlo[m]);
            chk({req, " high"}, int'(rd_high), mhi[m]);
        end
    endtask

    // Apply reset and walk the boot writes (R7)
    task automatic do_reset();
        @(negedge clk);
        rst_n    = 1'b0;
        wr_ready = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 reset req_ready", int'(req_ready), 0);
        chk("R7 reset rsp_ok",    int'(rsp_ok),    0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7 boot wr_valid 0", int'(wr_valid), 1);
        chk("R7 boot wr_mode 0",  int'(wr_mode),  0);
        chk("R7 boot wr_data 0",  int'(wr_data),  16'h0206);
        chk("R7 boot req_ready",  int'(req_ready), 0);
        @(negedge clk);
        chk("R10 boot hold", int'(wr_valid) | (int'(wr_mode) << 1), 1);
        wr_ready = 1'b1;
        @(negedge clk);
        chk("R7 boot wr_mode 1",  int'(wr_mode),  1);
        chk("R7 boot wr_data 1",  int'(wr_data),  16'h0206);
        chk("R7 boot req_ready 1", int'(req_ready), 0);
        @(negedge clk);
        wr_ready = 1'b0;
        chk("R7 boot done wr_valid", int'(wr_valid), 0);
        chk("R7 boot done req_ready", int'(req_ready), 1);
        for (int m = 0; m < 2; m++) begin
            mlo[m] = 2;
            mhi[m] = 4;
        end
        check_pairs("R7 defaults");
    endtask

    // Issue one request and check response, write and stored pairs
    task automatic run_vec(input vec_t v, input int idx);
        string tag;
        tag = $sformatf("vector %0d", idx);
        @(negedge clk);
        chk({"R10 ready before ", tag}, int'(req_ready), 1);
        req_valid  = 1'b1;
        req_mode   = v.mode;
        req_rising = v.rise;
        req_value  = v.val;
        @(negedge clk);
        req_valid = 1'b0;
        chk({"R2/R3 rsp_ok ", tag},  int'(rsp_ok),  int'(v.ok));
        chk({"R9 rsp_err ", tag},    int'(rsp_err), int'(!v.ok));
        chk({"R6 wr_valid ", tag},   int'(wr_valid), int'(v.wr));
        if (v.ok) begin
            mlo[v.mode] = int'(v.lo);
            mhi[v.mode] = int'(v.hi);
        end
        if (v.wr) begin
            chk({"R1 wr_data ", tag},  int'(wr_data), word_of(int'(v.lo), int'(v.hi)));
            chk({"R11 wr_mode ", tag}, int'(wr_mode), int'(v.mode));
            chk({"R10 no intake ", tag}, int'(req_ready), 0);
            @(negedge clk);
            chk({"R9 pulse ", tag}, int'(rsp_ok) | int'(rsp_err), 0);
            chk({"R10 held data ", tag}, int'(wr_data), word_of(int'(v.lo), int'(v.hi)));
            chk({"R10 held valid ", tag}, int'(wr_valid), 1);
            wr_ready = 1'b1;
            @(negedge clk);
            wr_ready = 1'b0;
            chk({"R10 write done ", tag}, int'(wr_valid), 0);
        end else begin
            chk({"R9 ready after ", tag}, int'(req_ready), 1);
            @(negedge clk);
            chk({"R9 pulse ", tag}, int'(rsp_ok) | int'(rsp_err), 0);
        end
        check_pairs({"R4/R5 pair ", tag});
    endtask

    // Decode one word and compare with the halved difference and total (R8)
    task automatic check_decode(input logic [15:0] w);
        int g, s;
        dec_word = w;
        #1;
        g = int'(w[15:8]);
        s = int'(w[7:0]);
        chk($sformatf("R8 decode low 0x%04h", w),  int'(dec_low),  (s - g) / 2);
        chk($sformatf("R8 decode high 0x%04h", w), int'(dec_high), (s + g) / 2);
    endtask

    initial begin
        do_reset();
        for (int i = 0; i < NV; i++) run_vec(VEC[i], i);
        check_decode(16'h0206);
        check_decode(16'h1418);
        check_decode(16'h022A);
        check_decode(16'h1218);
        check_decode(16'h060A);
        // Second reset after traffic restores the defaults (R7)
        do_reset();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule